// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a memory-mapped SPI master. Software configures a command register that sets word length, clock polarity and phase, transfer directions and chip-select handling. It then starts a burst by writing a control register with the word count minus one and a start bit. Transmit words are queued in a four-entry write FIFO and received words are collected in a four-entry read FIFO. Each entry holds one word, right-aligned.

During a burst the block shifts the counted words one after another, most significant bit first. SCLK runs at the system clock divided by a fixed parameter. When the last bit finishes, the block drops busy, sets a ready flag and clears the start bit. The ready flag, together with the interrupt enable for an active direction, drives the interrupt line. Software clears ready and the two FIFO error flags by writing ones to them, and it can flush either FIFO through the status register.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, status (offset 0x04) reads 0x02800000, which means both FIFOs are empty and all other flags are 0. The command register (0x00) reads 0, all four chip selects are high, and SCLK, MOSI and the interrupt are low.
- R2: Writing the control register (0x0C) with bit 31 set while idle starts a burst of (bits 15:0)+1 words. Busy (status bit 31) stays high for exactly words × length × 2 × CLK_DIV clock cycles. When busy falls, ready (status bit 30) is 1 and control bit 31 reads 0.
- R3: Each word sends the low L bits of a transmit entry MSB first, where L is command bits 4:0 plus 1. The received L bits are stored right-aligned with zeros above them, so a MOSI-to-MISO loopback returns the transmit word masked to L bits.
- R4: When idle, SCLK equals command bit 26. During a burst it produces one pulse away from that level per bit, and each half-period lasts CLK_DIV cycles. Command bit 21 = 0 holds the idle level in the first half of each bit. Bit 21 = 1 starts each bit at the opposite level.
- R5: With command bit 12 = 0, each chip select enabled in bits 8:5 (bit 5 is line 0) is active only while busy, and all lines are inactive otherwise. The active level is low, or high when command bit 16 is 1.
- R6: With command bit 12 = 1, every enabled chip-select line drives command bit 13 XOR bit 16, and lines that are not enabled sit at the inactive level.
- R7: With receive enabled (bit 14) and transmit disabled (bit 15 = 0), the burst still runs the counted words. MOSI stays 0 and the transmit FIFO is not consumed.
- R8: A write to the transmit port (0x10) while that FIFO is full drops the data and sets status bit 26.
- R9: A read of the receive port (0x20) while that FIFO is empty returns 0 and sets status bit 27.
- R10: Writing 1 to status bits 30, 27 or 26 clears the flag in that bit. Writing 0 to them leaves them unchanged.
- R11: The interrupt is high exactly when ready is set and either control bit 26 is set with transmit enabled, or control bit 27 is set with receive enabled.
- R12: Writing 1 to status bit 29 empties the transmit FIFO. Writing 1 to bit 28 empties the receive FIFO.
- R13: Status bits 25/24 show receive empty/full and bits 23/22 show transmit empty/full. Each FIFO is full at four entries.
- R14: Writes to the command and control registers are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 6 | Register byte address |
| busWe | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (pops the receive port) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCs | output | 4 | Chip-select lines |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check these properties on every cycle:
- ready is set and the start bit is clear whenever busy falls;
- SCLK sits at its idle level and hardware-controlled chip selects are inactive whenever the block is idle;
- MOSI stays low with transmit disabled;
- the interrupt never rises without ready;
- no FIFO reports empty and full together;
- the command register does not change inside a burst.

Only the bench scenarios can show the rest:
- the exact burst length in cycles and the number of SCLK pulses;
- the bit order and length masking seen through loopback;
- the phase of the first half-bit;
- the effect of overflow, underflow, flush and write-1-to-clear on later reads.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CMD = 6'h00;
  localparam logic [ADDR_W-1:0] A_STS = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTL = 6'h0C;
  localparam logic [ADDR_W-1:0] A_TX  = 6'h10;
  localparam logic [ADDR_W-1:0] A_RX  = 6'h20;
  localparam logic [31:0] CMD_MASK = 32'h0C21_F1FF;

  // control-to-datapath strobes
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
    logic load;
    logic sample;
    logic shift;
    logic rxStore;
  } dpStrobe_t;

  typedef struct packed {
    logic txEmpty;
    logic txFull;
    logic rxEmpty;
    logic rxFull;
  } fifoFlags_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 4,
  parameter int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              txEn,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxHead,
  output fifoFlags_t        flags
);
  logic [DATA_W-1:0] txHead, txShift, rxShift, lenMask;
  logic [LEN_W:0]    lenBits;
  logic [DATA_W:0]   wideMask;
  logic              txPop;

  assign lenBits  = {1'b0, lenM1} + 1'b1;
  assign wideMask = ({{DATA_W{1'b0}}, 1'b1} << lenBits) - 1'b1;
  assign lenMask  = wideMask[DATA_W-1:0];
  assign txPop    = stb.load && txEn;

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rst(rst), .push(stb.txPush), .pop(txPop), .flush(stb.txFlush),
    .wdata(busWdata), .rdata(txHead), .empty(flags.txEmpty), .full(flags.txFull)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rst(rst), .push(stb.rxStore), .pop(stb.rxPop), .flush(stb.rxFlush),
    .wdata(rxShift & lenMask), .rdata(rxHead), .empty(flags.rxEmpty), .full(flags.rxFull)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (stb.load)       txShift <= (txEn && !flags.txEmpty) ? txHead : '0;
      else if (stb.shift) txShift <= txShift << 1;
      if (stb.sample)     rxShift <= {rxShift[DATA_W-2:0], miso};
    end
  end

  assign mosi = txEn && txShift[lenM1];
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int CLK_DIV = 2,
  parameter int NUM_CS = 4,
  parameter int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  fifoFlags_t        flags,
  input  logic [DATA_W-1:0] rxHead,
  output dpStrobe_t         stb,
  output logic [LEN_W-1:0]  lenM1,
  output logic              txEn,
  output logic              spiSclk,
  output logic [NUM_CS-1:0] spiCs,
  output logic              irq
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic [31:0]       cmdQ;
  logic [CNT_W-1:0]  cntM1Q, wordIdxQ;
  logic [LEN_W-1:0]  bitIdxQ;
  logic [DIV_W-1:0]  halfCntQ;
  logic ieTxQ, ieRxQ, goQ, readyQ, txOvfQ, rxUnfQ, busyQ, secondQ;
  logic rxEn, swCs, csVal, csInv, cpha, cpol;
  logic [NUM_CS-1:0] csEnF;
  logic wrCmd, wrCtl, wrSts, wrTx, rdRx, start;
  logic halfDone, bitEnd, wordEnd, burstEnd;

  assign lenM1 = cmdQ[LEN_W-1:0];
  assign csEnF = cmdQ[5 +: NUM_CS];
  assign swCs  = cmdQ[12];
  assign csVal = cmdQ[13];
  assign rxEn  = cmdQ[14];
  assign txEn  = cmdQ[15];
  assign csInv = cmdQ[16];
  assign cpha  = cmdQ[21];
  assign cpol  = cmdQ[26];

  assign wrCmd = busWe && busAddr == A_CMD && !busyQ;
  assign wrCtl = busWe && busAddr == A_CTL && !busyQ;
  assign wrSts = busWe && busAddr == A_STS;
  assign wrTx  = busWe && busAddr == A_TX;
  assign rdRx  = busRd && busAddr == A_RX;
  assign start = wrCtl && busWdata[31];

  assign halfDone = busyQ && halfCntQ == DIV_W'(CLK_DIV - 1);
  assign bitEnd   = halfDone && secondQ;
  assign wordEnd  = bitEnd && bitIdxQ == lenM1;
  assign burstEnd = wordEnd && wordIdxQ == cntM1Q;

  always_comb begin
    stb.txPush  = wrTx;
    stb.rxPop   = rdRx;
    stb.txFlush = wrSts && busWdata[29];
    stb.rxFlush = wrSts && busWdata[28];
    stb.load    = start || (wordEnd && !burstEnd);
    stb.sample  = halfDone && !secondQ;
    stb.shift   = bitEnd && !wordEnd;
    stb.rxStore = wordEnd && rxEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ <= '0; cntM1Q <= '0; ieTxQ <= 1'b0; ieRxQ <= 1'b0; goQ <= 1'b0;
      readyQ <= 1'b0; txOvfQ <= 1'b0; rxUnfQ <= 1'b0; busyQ <= 1'b0;
      secondQ <= 1'b0; halfCntQ <= '0; bitIdxQ <= '0; wordIdxQ <= '0;
    end else begin
      if (wrCmd) cmdQ <= busWdata & CMD_MASK;
      if (wrCtl) begin
        cntM1Q <= busWdata[CNT_W-1:0];
        ieTxQ  <= busWdata[26];
        ieRxQ  <= busWdata[27];
        goQ    <= busWdata[31];
      end
      if (start) begin
        busyQ <= 1'b1; secondQ <= 1'b0; halfCntQ <= '0;
        bitIdxQ <= '0; wordIdxQ <= '0;
      end else if (busyQ) begin
        halfCntQ <= halfDone ? '0 : halfCntQ + 1'b1;
        if (halfDone) secondQ <= !secondQ;
        if (bitEnd) bitIdxQ <= wordEnd ? '0 : bitIdxQ + 1'b1;
        if (wordEnd && !burstEnd) wordIdxQ <= wordIdxQ + 1'b1;
        if (burstEnd) begin
          busyQ <= 1'b0;
          goQ   <= 1'b0;
        end
      end
      if (burstEnd) readyQ <= 1'b1;
      else if (wrSts && busWdata[30]) readyQ <= 1'b0;
      if (wrTx && flags.txFull) txOvfQ <= 1'b1;
      else if (wrSts && busWdata[26]) txOvfQ <= 1'b0;
      if (rdRx && flags.rxEmpty) rxUnfQ <= 1'b1;
      else if (wrSts && busWdata[27]) rxUnfQ <= 1'b0;
    end
  end

  always_comb begin
    case (busAddr)
      A_CMD:   busRdata = cmdQ;
      A_STS:   busRdata = {busyQ, readyQ, 2'b00, rxUnfQ, txOvfQ, flags.rxEmpty,
                           flags.rxFull, flags.txEmpty, flags.txFull, 22'd0};
      A_CTL:   busRdata = {goQ, 3'b000, ieRxQ, ieTxQ, {(26-CNT_W){1'b0}}, cntM1Q};
      A_RX:    busRdata = flags.rxEmpty ? 32'd0 : rxHead;
      default: busRdata = 32'd0;
    endcase
  end

  assign spiSclk = cpol ^ (busyQ & (secondQ ^ cpha));
  assign irq = readyQ && ((ieTxQ && txEn) || (ieRxQ && rxEn));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_comb begin
      if (swCs) spiCs[i] = csEnF[i] ? (csVal ^ csInv) : !csInv;
      else      spiCs[i] = (csEnF[i] && busyQ) ? csInv : !csInv;
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CLK_DIV = 2,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  busAddr,
  input  logic        busWe,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic [3:0]  spiCs,
  output logic        irq
);
  localparam int DATA_W = 32;
  localparam int LEN_W = $clog2(DATA_W);
  localparam int NUM_CS = 4;

  dpStrobe_t         stb;
  fifoFlags_t        flags;
  logic [DATA_W-1:0] rxHead;
  logic [LEN_W-1:0]  lenM1;
  logic              txEn;

  spim_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV),
              .NUM_CS(NUM_CS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .flags(flags), .rxHead(rxHead),
    .stb(stb), .lenM1(lenM1), .txEn(txEn), .spiSclk(spiSclk), .spiCs(spiCs),
    .irq(irq)
  );

  spim_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .busWdata(busWdata), .lenM1(lenM1),
    .txEn(txEn), .miso(spiMiso), .mosi(spiMosi), .rxHead(rxHead), .flags(flags)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        ready,
  input logic        goBit,
  input logic [31:0] cmdWord,
  input logic        spiSclk,
  input logic        spiMosi,
  input logic [3:0]  spiCs,
  input logic        irq,
  input logic        txEmpty,
  input logic        txFull,
  input logic        rxEmpty,
  input logic        rxFull
);
  // R2
  burst_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (ready && !goBit));
  // R2
  busy_go_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> goBit);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spiSclk == cmdWord[26]));
  // R5
  hw_cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmdWord[12]) |-> (spiCs == {4{!cmdWord[16]}}));
  // R7
  rx_only_mosi_chk: assert property (@(posedge clk) disable iff (rst)
    !cmdWord[15] |-> !spiMosi);
  // R11
  irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ready);
  // R13
  fifo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !(txEmpty && txFull) && !(rxEmpty && rxFull));
  // R14
  cmd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmdWord));
endmodule

bind spi_burst_master spim_chk u_chk (
  .clk(clk), .rst(rst), .busy(u_ctrl.busyQ), .ready(u_ctrl.readyQ),
  .goBit(u_ctrl.goQ), .cmdWord(u_ctrl.cmdQ), .spiSclk(spiSclk),
  .spiMosi(spiMosi), .spiCs(spiCs), .irq(irq),
  .txEmpty(u_dp.flags.txEmpty), .txFull(u_dp.flags.txFull),
  .rxEmpty(u_dp.flags.rxEmpty), .rxFull(u_dp.flags.rxFull)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
  localparam int DIV = 2;
  localparam logic [5:0] A_CMD = 6'h00, A_STS = 6'h04, A_CTL = 6'h0C,
                         A_TX = 6'h10, A_RX = 6'h20;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] busAddr = '0;
  logic busWe = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic spiSclk, spiMosi, spiMiso, irq;
  logic [3:0] spiCs;
  logic forceMiso = 1'b0;
  int checks = 0, fails = 0;
  logic [31:0] txw [4];

  always #4 clk = ~clk;
  assign spiMiso = forceMiso ? 1'b1 : spiMosi;

  spi_burst_master u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCs(spiCs), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1; #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  function automatic logic [31:0] maskOf(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
  endfunction

  task automatic runBurst(input int n, input int len, input int cpol, input int cpha,
                          input int cs, input int inv, input int tx, input int ie);
    logic [31:0] cmd, d, expCs;
    int cyc, pulses, csBad, mosiBad;
    logic prevS;
    busWrite(A_STS, 32'h7C00_0000);
    if (tx != 0) for (int k = 0; k < n; k++) busWrite(A_TX, txw[k]);
    else for (int k = 0; k < 2; k++) busWrite(A_TX, txw[k]);
    cmd = 32'(len - 1) | (32'h1 << (5 + cs)) | 32'h4000 | (tx != 0 ? 32'h8000 : 32'h0)
        | (32'(inv) << 16) | (32'(cpha) << 21) | (32'(cpol) << 26);
    busWrite(A_CMD, cmd);
    expCs = (inv != 0) ? (32'h1 << cs) : (32'hF & ~(32'h1 << cs));
    busWrite(A_CTL, 32'h8000_0000 | (32'(ie) << 26) | (32'(ie) << 27) | 32'(n - 1));
    busAddr = A_STS; #1;
    cyc = 0; pulses = 0; csBad = 0; mosiBad = 0; prevS = 1'(cpol);
    while (busRdata[31] && cyc < 5000) begin
      if (cyc == 0) chk("R4 first half-bit level", 32'(spiSclk), 32'(cpol ^ cpha));
      if (spiSclk !== 1'(cpol) && prevS === 1'(cpol)) pulses++;
      prevS = spiSclk;
      if (32'(spiCs) !== expCs) csBad++;
      if (tx == 0 && spiMosi !== 1'b0) mosiBad++;
      cyc++;
      @(negedge clk); #1;
    end
    chk("R2 busy cycles", 32'(cyc), 32'(n * len * 2 * DIV));
    chk("R4 sclk pulses", 32'(pulses), 32'(n * len));
    chk("R5 cs during burst", 32'(csBad), 32'd0);
    chk("R5 cs idle", 32'(spiCs), (inv != 0) ? 32'h0 : 32'hF);
    if (tx == 0) chk("R7 mosi idle level", 32'(mosiBad), 32'd0);
    chk("R2 ready set", 32'(busRdata[30]), 32'd1);
    busAddr = A_CTL; #1;
    chk("R2 start bit cleared", 32'(busRdata[31]), 32'd0);
    for (int k = 0; k < n; k++) begin
      busRead(A_RX, d);
      chk("R3 received word", d, (forceMiso ? 32'hFFFF_FFFF : txw[k]) & maskOf(len));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int lens [8] = '{8, 5, 32, 1, 16, 3, 24, 13};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    busAddr = A_STS; #1;
    chk("R1 status reset", busRdata, 32'h0280_0000);
    busAddr = A_CMD; #1;
    chk("R1 command reset", busRdata, 32'h0);
    chk("R1 pins reset", {26'd0, spiCs, spiSclk, spiMosi, irq}, 32'h78);

    // R3 R4 R5 sweep over length, count, mode, chip select and polarity
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 4; k++) txw[k] = 32'h9E37_79B9 * 32'(i * 4 + k + 1);
      runBurst((i % 4) + 1, lens[i], i & 1, (i >> 1) & 1, (i + 1) % 4, (i >= 4) ? 1 : 0, 1, 0);
      chk("R11 irq stays low without enable", 32'(irq), 32'd0);
    end

    // R7 receive only
    forceMiso = 1'b1;
    runBurst(3, 12, 0, 0, 1, 0, 0, 0);
    busAddr = A_STS; #1;
    chk("R7 tx fifo untouched", 32'(busRdata[23]), 32'd0);
    forceMiso = 1'b0;

    // R11 R10 interrupt and clear-on-one
    txw[0] = 32'h0000_00C5;
    runBurst(1, 8, 0, 0, 0, 0, 1, 1);
    chk("R11 irq on completion", 32'(irq), 32'd1);
    busWrite(A_STS, 32'h0);
    busAddr = A_STS; #1;
    chk("R10 write 0 keeps ready", 32'(busRdata[30]), 32'd1);
    busWrite(A_STS, 32'h4000_0000);
    busAddr = A_STS; #1;
    chk("R10 write 1 clears ready", 32'(busRdata[30]), 32'd0);
    chk("R11 irq follows ready", 32'(irq), 32'd0);

    // R8 R13 overflow and full flags
    busWrite(A_STS, 32'h7C00_0000);
    for (int k = 0; k < 4; k++) txw[k] = 32'h1111_1111 * 32'(k + 3);
    for (int k = 0; k < 4; k++) busWrite(A_TX, txw[k]);
    busAddr = A_STS; #1;
    chk("R13 tx full flags", {30'd0, busRdata[23], busRdata[22]}, 32'h1);
    busWrite(A_TX, 32'hDEAD_BEEF);
    busAddr = A_STS; #1;
    chk("R8 overflow flag", 32'(busRdata[26]), 32'd1);
    busWrite(A_CMD, 32'h0000_C01F);
    busWrite(A_CTL, 32'h8000_0003);
    busAddr = A_STS; #1;
    while (busRdata[31]) begin @(negedge clk); #1; end
    chk("R13 rx full tx empty", {28'd0, busRdata[25:22]}, 32'h6);
    for (int k = 0; k < 4; k++) begin
      busRead(A_RX, d);
      chk("R8 dropped word absent", d, txw[k]);
    end
    busRead(A_RX, d);
    chk("R9 empty read returns 0", d, 32'h0);
    busAddr = A_STS; #1;
    chk("R9 underflow flag", 32'(busRdata[27]), 32'd1);
    busWrite(A_STS, 32'h0C00_0000);
    busAddr = A_STS; #1;
    chk("R10 error flags cleared", {30'd0, busRdata[27:26]}, 32'h0);

    // R12 flush
    busWrite(A_TX, 32'h5);
    busWrite(A_TX, 32'h6);
    busWrite(A_STS, 32'h2000_0000);
    busAddr = A_STS; #1;
    chk("R12 tx flush", 32'(busRdata[23]), 32'd1);
    busWrite(A_TX, 32'h7);
    busWrite(A_CTL, 32'h8000_0000);
    busAddr = A_STS; #1;
    while (busRdata[31]) begin @(negedge clk); #1; end
    chk("R12 rx holds data", 32'(busRdata[25]), 32'd0);
    busWrite(A_STS, 32'h1000_0000);
    busAddr = A_STS; #1;
    chk("R12 rx flush", 32'(busRdata[25]), 32'd1);

    // R14 writes ignored while busy
    busWrite(A_STS, 32'h7C00_0000);
    for (int k = 0; k < 4; k++) busWrite(A_TX, 32'h0);
    busWrite(A_CMD, 32'h0000_C01F);
    busWrite(A_CTL, 32'h8000_0003);
    busWrite(A_CMD, 32'hFFFF_FFFF);
    busWrite(A_CTL, 32'h0C00_0001);
    busAddr = A_STS; #1;
    while (busRdata[31]) begin @(negedge clk); #1; end
    busAddr = A_CMD; #1;
    chk("R14 command kept", busRdata, 32'h0000_C01F);
    busAddr = A_CTL; #1;
    chk("R14 control kept", busRdata, 32'h0000_0003);

    // R6 software chip select on line 2
    busWrite(A_CMD, 32'h0000_1080);
    chk("R6 sw select low", 32'(spiCs), 32'hB);
    busWrite(A_CMD, 32'h0000_3080);
    chk("R6 sw select high", 32'(spiCs), 32'hF);
    busWrite(A_CMD, 32'h0001_1080);
    chk("R6 sw select inverted", 32'(spiCs), 32'h4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule